// File: doc/BRIEF.md
# Dual-CPU Shared-Bus Switch

This block lets a secondary CPU share a single memory bus with a host CPU, so that exactly one of the two runs at any moment. Each CPU has its own port with address, write data, read data, a write strobe and a request. The block forwards only the owning CPU's port to the system-side memory port. The CPU that is not selected gets a hold output and waits with its request pending.

Ownership is kept in a two-state machine. The state `ST_HOST_OWNS` (the state after reset) gives the bus to the host, and `ST_SEC_OWNS` gives it to the secondary CPU. The transition `HOST_TO_SEC` fires when the host writes to the switch page with data bit 0 set. The transition `SEC_TO_HOST` fires when the secondary CPU writes to the switch page with data bit 0 clear. A switch-page write that selects the current owner leaves the state where it is.

The secondary CPU's address is raised by a fixed offset before it reaches the system bus. This keeps its reset vector at address zero away from the host's I/O port, which also sits at zero. The switch page is decoded on the address as it appears on the system bus, after the offset has been added. Only plain memory reads and writes pass through the block; I/O cycles and interrupts do not.

Top module: `dual_cpu_bus_switch`

## Requirements
- R1: While reset is asserted, the host owns the bus: `host_hold` is 0 and `sec_hold` is 1.
- R2: In every cycle, exactly one of `host_hold` and `sec_hold` is 1.
- R3: While the host owns the bus, `sys_addr`, `sys_wdata` and `sys_req` equal the host's address, write data and request. `sys_we` equals `host_we AND host_req`.
- R4: While the secondary CPU owns the bus, `sys_addr` equals `(sec_addr + 0x1000) mod 65536`. `sys_wdata` and `sys_req` follow the secondary port, and `sys_we` equals `sec_we AND sec_req`.
- R5: A switch write selects the owner from the next cycle on. A switch write is a cycle with `sys_req=1`, `sys_we=1` and `sys_addr` in 0xDE00..0xDEFF. Bit 0 of `sys_wdata` picks the owner: 0 selects the host, 1 selects the secondary CPU.
- R6: Ownership stays the same in the cycle of a switch write. It also stays the same after any cycle that is not a switch write, including a read of the switch page and a write just outside that page.
- R7: The switch page is decoded after the offset is added. A secondary-CPU write to 0xCE00..0xCEFF is a switch write. A secondary-CPU write to 0xDE00..0xDEFF (which lands at 0xEE00..0xEEFF) is not.
- R8: The owner's read-data port returns `sys_rdata`. The other CPU's read-data port returns 0xFF.
- R9: Requests, strobes, addresses and data from the CPU on hold have no effect on the system port or on ownership.
- R10: The offset wraps: secondary addresses 0xF000..0xFFFF reach the system bus as 0x0000..0x0FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Host CPU address |
| host_wdata | input | 8 | Host CPU write data |
| host_we | input | 1 | Host CPU write strobe (1 = write) |
| host_req | input | 1 | Host CPU access request |
| host_rdata | output | 8 | Read data returned to the host |
| host_hold | output | 1 | Stall for the host (1 = not owner) |
| sec_addr | input | 16 | Secondary CPU address |
| sec_wdata | input | 8 | Secondary CPU write data |
| sec_we | input | 1 | Secondary CPU write strobe |
| sec_req | input | 1 | Secondary CPU access request |
| sec_rdata | output | 8 | Read data returned to the secondary CPU |
| sec_hold | output | 1 | Stall for the secondary CPU |
| sys_addr | output | 16 | System bus address |
| sys_wdata | output | 8 | System bus write data |
| sys_we | output | 1 | System bus write strobe |
| sys_req | output | 1 | System bus request |
| sys_rdata | input | 8 | System bus read data |

## Verification
The assertions assume that every access completes in the cycle it is presented. They also assume that reset is asserted from time zero and then released once, so that the cycle before any checked edge is either in reset or a normal cycle.

The stimulus respects both assumptions. Reset is held from the start for a few cycles and never asserted again. Every input changes only once per cycle, just after the rising edge. Random traffic is biased so that both ports often hit the raw and the offset switch page. This drives ownership back and forth many times, and the held CPU keeps issuing requests while it waits.

// File: rtl/dcbs_pkg.sv
package dcbs_pkg;

    typedef enum logic {
        ST_HOST_OWNS = 1'b0,
        ST_SEC_OWNS  = 1'b1
    } owner_state_e;

    localparam int unsigned DEF_ADDR_W     = 16;
    localparam int unsigned DEF_DATA_W     = 8;
    localparam int unsigned DEF_PAGE_SHIFT = 8;
    localparam int unsigned DEF_OFFSET     = 32'h0000_1000;
    localparam int unsigned DEF_PAGE_TAG   = 32'h0000_00DE;

endpackage

// File: rtl/dcbs_addr_offset.sv
module dcbs_addr_offset #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFFSET = 32'h1000
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam logic [ADDR_W-1:0] OFS = OFFSET[ADDR_W-1:0];

    // Sum is truncated to ADDR_W bits, so it wraps modulo the address space.
    always_comb begin
        addr_out = addr_in + OFS;
    end
endmodule

// File: rtl/dcbs_page_decode.sv
module dcbs_page_decode #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned PAGE_SHIFT = 8,
    parameter int unsigned PAGE_TAG   = 32'hDE
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_req,
    input  logic              bus_we,
    output logic              switch_wr
);
    localparam int unsigned TAG_W = ADDR_W - PAGE_SHIFT;
    localparam logic [TAG_W-1:0] TAG = PAGE_TAG[TAG_W-1:0];

    logic page_hit;

    always_comb begin
        page_hit  = (bus_addr[ADDR_W-1:PAGE_SHIFT] == TAG);
        switch_wr = bus_req & bus_we & page_hit;
    end
endmodule

// File: rtl/dcbs_owner_fsm.sv
module dcbs_owner_fsm
    import dcbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic switch_wr,
    input  logic sel_bit,
    output logic sec_owns,
    output logic host_hold,
    output logic sec_hold
);
    owner_state_e state_q;
    owner_state_e state_d;

    // Next-state logic: HOST_TO_SEC and SEC_TO_HOST transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOST_OWNS: if (switch_wr && sel_bit)  state_d = ST_SEC_OWNS;
            ST_SEC_OWNS:  if (switch_wr && !sel_bit) state_d = ST_HOST_OWNS;
            default:      state_d = ST_HOST_OWNS;
        endcase
    end

    // State register; the new owner takes effect after the write cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOST_OWNS;
        else        state_q <= state_d;
    end

    // Outputs decoded from the current state only.
    always_comb begin
        sec_owns  = 1'b0;
        host_hold = 1'b0;
        sec_hold  = 1'b1;
        unique case (state_q)
            ST_HOST_OWNS: begin
                sec_owns  = 1'b0;
                host_hold = 1'b0;
                sec_hold  = 1'b1;
            end
            ST_SEC_OWNS: begin
                sec_owns  = 1'b1;
                host_hold = 1'b1;
                sec_hold  = 1'b0;
            end
            default: begin
                sec_owns  = 1'b0;
                host_hold = 1'b0;
                sec_hold  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dcbs_bus_mux.sv
module dcbs_bus_mux #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              sec_owns,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] sec_addr_ofs,
    input  logic [DATA_W-1:0] sec_wdata,
    input  logic              sec_we,
    input  logic              sec_req,
    input  logic [DATA_W-1:0] sys_rdata,
    output logic [ADDR_W-1:0] sys_addr,
    output logic [DATA_W-1:0] sys_wdata,
    output logic              sys_we,
    output logic              sys_req,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] sec_rdata
);
    localparam logic [DATA_W-1:0] IDLE_DATA = {DATA_W{1'b1}};

    always_comb begin
        if (sec_owns) begin
            sys_addr  = sec_addr_ofs;
            sys_wdata = sec_wdata;
            sys_req   = sec_req;
            sys_we    = sec_req & sec_we;
        end else begin
            sys_addr  = host_addr;
            sys_wdata = host_wdata;
            sys_req   = host_req;
            sys_we    = host_req & host_we;
        end
        host_rdata = sec_owns ? IDLE_DATA : sys_rdata;
        sec_rdata  = sec_owns ? sys_rdata : IDLE_DATA;
    end
endmodule

// File: rtl/dual_cpu_bus_switch.sv
module dual_cpu_bus_switch #(
    parameter int unsigned ADDR_W     = dcbs_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W     = dcbs_pkg::DEF_DATA_W,
    parameter int unsigned PAGE_SHIFT = dcbs_pkg::DEF_PAGE_SHIFT,
    parameter int unsigned PAGE_TAG   = dcbs_pkg::DEF_PAGE_TAG,
    parameter int unsigned OFFSET     = dcbs_pkg::DEF_OFFSET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    input  logic              host_req,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_hold,
    input  logic [ADDR_W-1:0] sec_addr,
    input  logic [DATA_W-1:0] sec_wdata,
    input  logic              sec_we,
    input  logic              sec_req,
    output logic [DATA_W-1:0] sec_rdata,
    output logic              sec_hold,
    output logic [ADDR_W-1:0] sys_addr,
    output logic [DATA_W-1:0] sys_wdata,
    output logic              sys_we,
    output logic              sys_req,
    input  logic [DATA_W-1:0] sys_rdata
);
    logic [ADDR_W-1:0] sec_addr_ofs;
    logic              sec_owns;
    logic              switch_wr;

    dcbs_addr_offset #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_ofs (
        .addr_in  (sec_addr),
        .addr_out (sec_addr_ofs)
    );

    dcbs_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .sec_owns     (sec_owns),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_we      (host_we),
        .host_req     (host_req),
        .sec_addr_ofs (sec_addr_ofs),
        .sec_wdata    (sec_wdata),
        .sec_we       (sec_we),
        .sec_req      (sec_req),
        .sys_rdata    (sys_rdata),
        .sys_addr     (sys_addr),
        .sys_wdata    (sys_wdata),
        .sys_we       (sys_we),
        .sys_req      (sys_req),
        .host_rdata   (host_rdata),
        .sec_rdata    (sec_rdata)
    );

    // Decode on the system-side address, after the offset.
    dcbs_page_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_TAG(PAGE_TAG)) u_dec (
        .bus_addr  (sys_addr),
        .bus_req   (sys_req),
        .bus_we    (sys_we),
        .switch_wr (switch_wr)
    );

    dcbs_owner_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .switch_wr (switch_wr),
        .sel_bit   (sys_wdata[0]),
        .sec_owns  (sec_owns),
        .host_hold (host_hold),
        .sec_hold  (sec_hold)
    );
endmodule

// File: rtl/dual_cpu_bus_switch_chk.sv
module dual_cpu_bus_switch_chk #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PAGE_SHIFT = 8,
    parameter int unsigned PAGE_TAG   = 32'hDE,
    parameter int unsigned OFFSET     = 32'h1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_req,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_hold,
    input logic [ADDR_W-1:0] sec_addr,
    input logic [DATA_W-1:0] sec_rdata,
    input logic              sec_hold,
    input logic [ADDR_W-1:0] sys_addr,
    input logic [DATA_W-1:0] sys_wdata,
    input logic              sys_we,
    input logic              sys_req,
    input logic [DATA_W-1:0] sys_rdata
);
    localparam int unsigned TAG_W = ADDR_W - PAGE_SHIFT;
    localparam logic [TAG_W-1:0]  TAG = PAGE_TAG[TAG_W-1:0];
    localparam logic [ADDR_W-1:0] OFS = OFFSET[ADDR_W-1:0];

    logic sw_cycle;
    logic [ADDR_W-1:0] sec_expect;
    assign sw_cycle   = sys_req && sys_we && (sys_addr[ADDR_W-1:PAGE_SHIFT] == TAG);
    assign sec_expect = sec_addr + OFS;

    a_r1_reset_host: assert property (@(posedge clk) !rst_n |-> (!host_hold && sec_hold));

    a_r2_one_hold: assert property (@(posedge clk) disable iff (!rst_n)
        host_hold != sec_hold);

    a_r3_host_path: assert property (@(posedge clk) disable iff (!rst_n)
        !host_hold |-> (sys_addr == host_addr && sys_req == host_req));

    a_r4_sec_offset: assert property (@(posedge clk) disable iff (!rst_n)
        host_hold |-> (sys_addr == sec_expect));

    a_r5_switch_sel: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cycle |=> (sec_hold == !$past(sys_wdata[0])));

    a_r6_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_cycle |=> $stable(host_hold));

    a_r8_host_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
        host_hold |-> (host_rdata == {DATA_W{1'b1}} && sec_rdata == sys_rdata));

    a_r8_sec_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
        sec_hold |-> (sec_rdata == {DATA_W{1'b1}} && host_rdata == sys_rdata));
endmodule

bind dual_cpu_bus_switch dual_cpu_bus_switch_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT),
    .PAGE_TAG(PAGE_TAG), .OFFSET(OFFSET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_req   (host_req),
    .host_rdata (host_rdata),
    .host_hold  (host_hold),
    .sec_addr   (sec_addr),
    .sec_rdata  (sec_rdata),
    .sec_hold   (sec_hold),
    .sys_addr   (sys_addr),
    .sys_wdata  (sys_wdata),
    .sys_we     (sys_we),
    .sys_req    (sys_req),
    .sys_rdata  (sys_rdata)
);

// File: tb/dual_cpu_bus_switch_tb.sv
module dual_cpu_bus_switch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0, sec_addr = '0;
    logic [7:0]  host_wdata = '0, sec_wdata = '0, sys_rdata = '0;
    logic        host_we = 0, host_req = 0, sec_we = 0, sec_req = 0;
    logic [7:0]  host_rdata, sec_rdata, sys_wdata;
    logic        host_hold, sec_hold, sys_we, sys_req;
    logic [15:0] sys_addr;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    int model_sec = 0;          // 0: host owns, 1: secondary owns
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;       // 250 MHz

    dual_cpu_bus_switch u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we), .host_req(host_req),
        .host_rdata(host_rdata), .host_hold(host_hold),
        .sec_addr(sec_addr), .sec_wdata(sec_wdata), .sec_we(sec_we), .sec_req(sec_req),
        .sec_rdata(sec_rdata), .sec_hold(sec_hold),
        .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_we(sys_we), .sys_req(sys_req),
        .sys_rdata(sys_rdata)
    );

    function automatic logic [31:0] next_rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic cmp(input string tag, input string what, input int got, input int exp);
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
        end
    endtask

    // Compare all outputs at the falling edge, then advance the model at the rising edge.
    task automatic step(input string tag);
        int e_addr, e_wd, e_req, e_we, e_hr, e_sr;
        @(negedge clk);
        vectors++;
        if (model_sec != 0) begin
            e_addr = (int'(sec_addr) + 'h1000) % 65536;   // R4 and R10
            e_wd = sec_wdata; e_req = sec_req; e_we = sec_req & sec_we;
            e_hr = 'hFF; e_sr = sys_rdata;
        end else begin
            e_addr = host_addr;
            e_wd = host_wdata; e_req = host_req; e_we = host_req & host_we;
            e_hr = sys_rdata; e_sr = 'hFF;
        end
        cmp(tag, "host_hold", host_hold, model_sec);
        cmp(tag, "sec_hold", sec_hold, 1 - model_sec);
        cmp(tag, "sys_addr", sys_addr, e_addr);
        cmp(tag, "sys_wdata", sys_wdata, e_wd);
        cmp(tag, "sys_req", sys_req, e_req);
        cmp(tag, "sys_we", sys_we, e_we);
        cmp(tag, "host_rdata", host_rdata, e_hr);
        cmp(tag, "sec_rdata", sec_rdata, e_sr);
        @(posedge clk);
        if (!rst_n) model_sec = 0;
        else if (e_req != 0 && e_we != 0 && (e_addr / 256) == 'hDE)
            model_sec = e_wd % 2;
        #1;
    endtask

    task automatic host_set(input logic [15:0] a, input logic [7:0] d, input logic w, input logic r);
        host_addr = a; host_wdata = d; host_we = w; host_req = r;
    endtask

    task automatic sec_set(input logic [15:0] a, input logic [7:0] d, input logic w, input logic r);
        sec_addr = a; sec_wdata = d; sec_we = w; sec_req = r;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with the secondary port trying to write the page.
        sec_set(16'hCE00, 8'h01, 1, 1);
        host_set(16'h1234, 8'h55, 0, 1);
        sys_rdata = 8'h3C;
        for (int i = 0; i < 4; i++) step("R1");
        @(negedge clk); rst_n = 1'b1; @(posedge clk); #1;

        // R3 and R8: host reads, with several data patterns.
        host_set(16'h0000, 8'hA5, 0, 1); sys_rdata = 8'h00; step("R3");
        host_set(16'hFFFF, 8'h5A, 0, 1); sys_rdata = 8'hC3; step("R8");
        host_set(16'h8001, 8'h77, 1, 0); sys_rdata = 8'h81; step("R3");
        // R9: held secondary writes to the offset page, with no effect.
        sec_set(16'hCE10, 8'h01, 1, 1); host_set(16'h2000, 8'h11, 0, 0); step("R9");
        step("R9");
        // R6: page read, below-page and above-page writes, page write choosing the host.
        host_set(16'hDE40, 8'h01, 0, 1); step("R6");
        host_set(16'hDDFF, 8'h01, 1, 1); step("R6");
        host_set(16'hDF00, 8'h01, 1, 1); step("R6");
        host_set(16'hDE05, 8'h00, 1, 1); step("R6");
        // R5: switching write at the top of the page; the owner is unchanged in this cycle.
        host_set(16'hDEFF, 8'h01, 1, 1); step("R5");
        host_set(16'hDE00, 8'h00, 1, 1);                 // host now held: ignored (R9)
        sec_set(16'h0000, 8'h42, 0, 1); sys_rdata = 8'h9E; step("R5");
        // R4: zero address lands at the offset.
        sec_set(16'h0000, 8'h42, 1, 1); step("R4");
        // R10: wrap at the top of the address space.
        sec_set(16'hF123, 8'h10, 0, 1); step("R10");
        sec_set(16'hFFFF, 8'h10, 1, 1); step("R10");
        // R7: a raw page address from the secondary lands at 0xEE00 and does not switch.
        sec_set(16'hDE00, 8'h00, 1, 1); step("R7");
        step("R7");
        // R7: an offset page address switches back to the host (bit 0 = 0).
        sec_set(16'hCEFF, 8'h02, 1, 1); step("R7");
        host_set(16'h4000, 8'h00, 0, 1); step("R7");
        // R5: a page write that selects the current owner leaves it in place.
        host_set(16'hDE80, 8'hFE, 1, 1); step("R5");
        step("R2");

        // Random traffic, biased towards both page forms.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r1, r2;
            r1 = next_rnd(); r2 = next_rnd();
            host_set(r1[15:0], r1[23:16], r1[24], r1[25] | r1[26]);
            sec_set(r2[15:0], r2[23:16], r2[24], r2[25] | r2[26]);
            if (r1[29:27] == 3'd0) host_addr[15:8] = 8'hDE;
            if (r2[29:27] == 3'd0) sec_addr[15:8]  = 8'hCE;
            if (r2[29:27] == 3'd1) sec_addr[15:8]  = 8'hDE;
            sys_rdata = r1[31:24] ^ r2[31:24];
            step("R2");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule